// File: doc/BRIEF.md
# Write-Through Flush Completion Tracker

This block sits next to a write-through data cache and decides when a release-style flush has finished. It counts write-throughs that have been sent toward the next cache level but not yet acknowledged, and keeps a second counter of completion credits gathered while a flush is in progress. A flush is reported complete only once every write-through issued ahead of it has come back acknowledged, and that is worked out by comparing the two counters. It does not wait on any single transaction.

The cache controller pulses `wt_issue` for each write-through it sends and `wt_ack` for each acknowledgement it receives. During a flush walk it pulses `flush_dirty` for a dirty line, which also counts as a write-through issue, or `flush_clean` for a clean line. The block answers with a one-cycle `flush_done` pulse and an `in_flush` level. It also raises a sticky `underflow_err` if an acknowledgement arrives when nothing is outstanding. All outputs are registered, so each one reflects the inputs sampled at the previous rising edge.

Top module: `write_through_flush_tracker`

## Requirements
- R1: While reset is held low and in the first cycle after it, `in_flush`, `flush_done` and `underflow_err` are all 0.
- R2: The outstanding count rises by one for each of `wt_issue` and `flush_dirty` asserted in a cycle and falls by one for each accepted `wt_ack`. This shows as the number of acknowledgements needed before a pending flush completes.
- R3: Either kind of flush sets `in_flush` from the next cycle, unless that same cycle's completion step already clears it.
- R4: A dirty-line flush on its own produces no completion step and no `flush_done`.
- R5: A completion step adds one to the flush counter, saturating at 255. If the flush counter is then greater than the outstanding count, `flush_done` pulses in the next cycle and the flush counter drops by one. A clean-line flush with nothing outstanding therefore yields `flush_done` at once.
- R6: An accepted acknowledgement that arrives while in flush (counting a flush that starts in the same cycle) first takes one off the outstanding count and one off the flush counter, with a floor of 0. It then performs a completion step. After a clean flush that follows N outstanding write-throughs, `flush_done` comes with the Nth acknowledgement and not before.
- R7: An acknowledgement that arrives when the outstanding count, including any issue in the same cycle, is zero sets `underflow_err`. That flag stays at 1 until reset. The acknowledgement is otherwise ignored: no count changes and no completion step.
- R8: When an issue and an acknowledgement arrive in the same cycle, the issue is counted first, so the count is unchanged and the acknowledgement is accepted even from zero.
- R9: The outstanding count is 8 bits wide and saturates at 255. After 256 issues, 255 acknowledgements are accepted and the 256th raises `underflow_err`.
- R10: `in_flush` clears only after a completion step that leaves both counters at zero.
- R11: If a clean flush and an accepted acknowledgement arrive in the same cycle, the acknowledgement's decrement and step come before the clean flush's step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wt_issue | input | 1 | Pulse: a write-through was sent |
| wt_ack | input | 1 | Pulse: a write-through acknowledgement was received |
| flush_dirty | input | 1 | Pulse: flush of a dirty line, which also sends a write-through |
| flush_clean | input | 1 | Pulse: flush of a clean line |
| flush_done | output | 1 | One-cycle pulse: flush completion |
| in_flush | output | 1 | A flush is in progress |
| underflow_err | output | 1 | Sticky: acknowledgement arrived with nothing outstanding |

## Verification
The hardest situations to reach are the ones where several events share a cycle while a flush is active and the counters sit near their limits. Examples are a clean flush landing together with the acknowledgement that empties the outstanding count, and an acknowledgement in the same cycle as an issue when the count is zero. Directed sequences build these states step by step, and one of them pushes the count into saturation with 256 issues. A long seeded random phase then drives all four inputs with biased probabilities. Acknowledgements are only sent while a bench-side model reports write-throughs outstanding, so the random runs stay error-free and keep reaching flush completions.

// File: rtl/wtf_pkg.sv
// Package: shared constants for the write-through flush tracker.
// Assumes: completion steps are handled in a fixed slot order each cycle.
package wtf_pkg;
    // Number of completion-step slots a single cycle can carry.
    localparam int STEP_SLOTS = 2;

    // Slot order: the acknowledgement step always precedes the clean-flush step.
    typedef enum logic {
        SLOT_ACK   = 1'b0,
        SLOT_CLEAN = 1'b1
    } step_slot_e;
endpackage

// File: rtl/wtf_tally.sv
// Module: wtf_tally
// Keeps the saturating count of write-throughs issued but not yet acknowledged.
// The same-cycle issues are added before the acknowledgement is judged.
// An acknowledgement that finds the count at zero is refused, and it sets a
// sticky underflow flag.
// Assumes: at most two issues per cycle (plain issue plus dirty flush).
module wtf_tally #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   issue_cnt,
    input  logic         ack,
    output logic [W-1:0] count,
    output logic [W-1:0] count_next,
    output logic         ack_ok,
    output logic         underflow
);
    localparam logic [W-1:0]   MAXV  = '1;
    localparam logic [W-1:0]   ONE   = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W+1:0]   MAXW  = {2'b00, MAXV};

    logic [W+1:0] wide_sum;
    logic [W-1:0] post_inc;

    // Add issues with saturation, then accept or refuse the acknowledgement.
    always_comb begin
        wide_sum   = {2'b00, count} + {{W{1'b0}}, issue_cnt};
        post_inc   = (wide_sum > MAXW) ? MAXV : wide_sum[W-1:0];
        ack_ok     = ack && (post_inc != '0);
        count_next = ack_ok ? (post_inc - ONE) : post_inc;
    end

    // Register the count and the sticky underflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count     <= '0;
            underflow <= 1'b0;
        end else begin
            count <= count_next;
            if (ack && (post_inc == '0)) begin
                underflow <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/wtf_stepper.sv
// Module: wtf_stepper
// Holds the flush credit counter and applies up to two completion steps per
// cycle, in package slot order. A step adds one credit. If credits then
// exceed the outstanding count, it signals completion and gives the credit back.
// An accepted acknowledgement during a flush first removes one credit (floor 0).
// Assumes: out_next is the outstanding count after this cycle's issue/ack.
module wtf_stepper
    import wtf_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ack_ok,
    input  logic         clean,
    input  logic         flag_pre,
    input  logic [W-1:0] out_next,
    output logic [W-1:0] fcnt,
    output logic [W-1:0] fcnt_next,
    output logic         done_next,
    output logic         stepped
);
    localparam logic [W-1:0] MAXV = '1;
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    logic [STEP_SLOTS-1:0] req;
    logic [W-1:0]          f;

    // Gather the step requests, one per slot.
    always_comb begin
        req                  = '0;
        req[int'(SLOT_ACK)]   = ack_ok && flag_pre;
        req[int'(SLOT_CLEAN)] = clean;
    end

    // Apply the acknowledgement decrement and then each step in slot order.
    always_comb begin
        f         = fcnt;
        done_next = 1'b0;
        stepped   = 1'b0;
        if (req[int'(SLOT_ACK)] && (f != '0)) begin
            f = f - ONE;
        end
        for (int s = 0; s < STEP_SLOTS; s++) begin
            if (req[s]) begin
                stepped = 1'b1;
                if (f != MAXV) begin
                    f = f + ONE;
                end
                if (f > out_next) begin
                    done_next = 1'b1;
                    f         = f - ONE;
                end
            end
        end
        fcnt_next = f;
    end

    // Register the credit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcnt <= '0;
        end else begin
            fcnt <= fcnt_next;
        end
    end
endmodule

// File: rtl/write_through_flush_tracker.sv
// Module: write_through_flush_tracker (top)
// Tracks outstanding write-throughs and reports when a flush has completed.
// A dirty flush counts as a write-through issue. Clean flushes, and
// acknowledgements seen during a flush, drive completion steps.
// The in-flush flag drops once a step leaves both counters at zero.
// Assumes: inputs are single-cycle pulses synchronous to clk; reset is
// synchronous and active low.
module write_through_flush_tracker #(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wt_issue,
    input  logic wt_ack,
    input  logic flush_dirty,
    input  logic flush_clean,
    output logic flush_done,
    output logic in_flush,
    output logic underflow_err
);
    logic [1:0]   issue_cnt;
    logic [W-1:0] out_cnt;
    logic [W-1:0] out_next;
    logic         ack_ok;
    logic [W-1:0] fl_cnt;
    logic [W-1:0] fl_next;
    logic         done_next;
    logic         stepped;
    logic         flag_pre;
    logic         flag_next;

    // Count the write-throughs started this cycle.
    always_comb begin
        issue_cnt = {1'b0, wt_issue} + {1'b0, flush_dirty};
    end

    wtf_tally #(.W(W)) u_tally (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_cnt  (issue_cnt),
        .ack        (wt_ack),
        .count      (out_cnt),
        .count_next (out_next),
        .ack_ok     (ack_ok),
        .underflow  (underflow_err)
    );

    // A flush of either kind raises the flag before steps are judged.
    always_comb begin
        flag_pre  = in_flush || flush_dirty || flush_clean;
        flag_next = flag_pre &&
                    !(stepped && (out_next == '0) && (fl_next == '0));
    end

    wtf_stepper #(.W(W)) u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_ok    (ack_ok),
        .clean     (flush_clean),
        .flag_pre  (flag_pre),
        .out_next  (out_next),
        .fcnt      (fl_cnt),
        .fcnt_next (fl_next),
        .done_next (done_next),
        .stepped   (stepped)
    );

    // Register the flag and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_flush   <= 1'b0;
            flush_done <= 1'b0;
        end else begin
            in_flush   <= flag_next;
            flush_done <= done_next;
        end
    end
endmodule

// File: rtl/wtf_checker.sv
// Module: wtf_checker
// Temporal checks on the tracker's ports and counters, bound into the top.
// Assumes: synchronous active-low reset, 8-bit default counters.
module wtf_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wt_issue,
    input logic         wt_ack,
    input logic         flush_dirty,
    input logic         flush_clean,
    input logic         flush_done,
    input logic         in_flush,
    input logic         underflow_err,
    input logic [W-1:0] out_cnt,
    input logic [W-1:0] fl_cnt
);
    localparam logic [W-1:0] MAXV = '1;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_err |=> underflow_err); // R7

    AST_UNDERFLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wt_ack && !wt_issue && !flush_dirty && out_cnt == '0)
        |=> (underflow_err && out_cnt == '0)); // R7

    AST_ISSUE_INC: assert property (@(posedge clk) disable iff (!rst_n)
        ((wt_issue ^ flush_dirty) && !wt_ack && out_cnt != MAXV)
        |=> (out_cnt == $past(out_cnt) + 1'b1)); // R2

    AST_SAME_CYCLE_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (wt_issue && wt_ack && !flush_dirty && out_cnt != MAXV)
        |=> $stable(out_cnt)); // R8

    AST_DIRTY_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_dirty && !wt_ack) |=> in_flush); // R3

    AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |-> $past(flush_clean || wt_ack)); // R4

    AST_IDLE_NO_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_flush |-> (fl_cnt == '0)); // R10
endmodule

bind write_through_flush_tracker wtf_checker #(.W(W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wt_issue      (wt_issue),
    .wt_ack        (wt_ack),
    .flush_dirty   (flush_dirty),
    .flush_clean   (flush_clean),
    .flush_done    (flush_done),
    .in_flush      (in_flush),
    .underflow_err (underflow_err),
    .out_cnt       (out_cnt),
    .fl_cnt        (fl_cnt)
);

// File: tb/sim_write_through_flush_tracker.sv
`timescale 1ns/1ps
module sim_write_through_flush_tracker;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wt_issue = 1'b0, wt_ack = 1'b0, flush_dirty = 1'b0, flush_clean = 1'b0;
    logic flush_done, in_flush, underflow_err;

    int n_checks = 0;
    int n_fail = 0;
    bit summary_done = 1'b0;

    // bench reference state
    int  m_out, m_f;
    bit  m_flag, m_err, m_done;

    always #2.5 clk = ~clk;

    write_through_flush_tracker u0 (
        .clk(clk), .rst_n(rst_n), .wt_issue(wt_issue), .wt_ack(wt_ack),
        .flush_dirty(flush_dirty), .flush_clean(flush_clean),
        .flush_done(flush_done), .in_flush(in_flush), .underflow_err(underflow_err)
    );

    function automatic void model_reset();
        m_out = 0; m_f = 0; m_flag = 0; m_err = 0; m_done = 0;
    endfunction

    function automatic void model_step_one(input int no, inout int f, inout bit done);
        if (f < 255) f = f + 1;
        if (f > no) begin done = 1; f = f - 1; end
    endfunction

    function automatic void model_cycle(input bit i, input bit a, input bit d, input bit c);
        int po, no, f;
        bit ok, fl, st, done;
        po = m_out + int'(i) + int'(d);
        if (po > 255) po = 255;
        ok = a && (po != 0);
        if (a && po == 0) m_err = 1;
        no = ok ? po - 1 : po;
        fl = m_flag | d | c;
        f = m_f; st = 0; done = 0;
        if (ok && fl) begin
            if (f > 0) f = f - 1;
            st = 1;
            model_step_one(no, f, done);
        end
        if (c) begin
            st = 1;
            model_step_one(no, f, done);
        end
        if (st && no == 0 && f == 0) fl = 0;
        m_out = no; m_f = f; m_flag = fl; m_done = done;
    endfunction

    task automatic check(input bit got, input bit exp, input string req, input string what);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic check_model(input string req);
        check(flush_done, m_done, req, "flush_done");
        check(in_flush, m_flag, req, "in_flush");
        check(underflow_err, m_err, req, "underflow_err");
    endtask

    // Drive one cycle at the falling edge, update model after the rise, compare at next fall.
    task automatic tick(input bit i, input bit a, input bit d, input bit c, input string req);
        wt_issue = i; wt_ack = a; flush_dirty = d; flush_clean = c;
        @(posedge clk);
        model_cycle(i, a, d, c);
        @(negedge clk);
        wt_issue = 0; wt_ack = 0; flush_dirty = 0; flush_clean = 0;
        check_model(req);
    endtask

    task automatic do_reset();
        rst_n = 0;
        wt_issue = 0; wt_ack = 0; flush_dirty = 0; flush_clean = 0;
        repeat (2) @(negedge clk);
        check(flush_done, 0, "R1", "flush_done in reset");
        check(in_flush, 0, "R1", "in_flush in reset");
        check(underflow_err, 0, "R1", "underflow_err in reset");
        rst_n = 1;
        model_reset();
        tick(0, 0, 0, 0, "R1");
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        // R5: clean flush with nothing outstanding completes at once
        do_reset();
        tick(0, 0, 0, 1, "R5");
        check(flush_done, 1, "R5", "immediate done");
        check(in_flush, 0, "R5", "flag cleared same step");
        tick(0, 0, 0, 0, "R10");
        check(flush_done, 0, "R10", "done is one cycle");

        // R6: clean flush behind three write-throughs
        do_reset();
        repeat (3) tick(1, 0, 0, 0, "R2");
        tick(0, 0, 0, 1, "R3");
        check(in_flush, 1, "R3", "clean flush sets flag");
        tick(0, 1, 0, 0, "R6");
        tick(0, 1, 0, 0, "R6");
        check(flush_done, 0, "R6", "no early done");
        tick(0, 1, 0, 0, "R6");
        check(flush_done, 1, "R6", "done on last ack");
        check(in_flush, 0, "R10", "flag clears with both zero");

        // R4: dirty flush alone raises flag, no done
        do_reset();
        tick(0, 0, 1, 0, "R4");
        check(flush_done, 0, "R4", "dirty flush no done");
        check(in_flush, 1, "R3", "dirty flush sets flag");
        tick(0, 1, 0, 0, "R6");
        check(flush_done, 1, "R6", "ack completes dirty flush");

        // R11: clean flush and ack together, ack ordered first
        do_reset();
        repeat (2) tick(1, 0, 0, 0, "R2");
        tick(0, 1, 0, 1, "R11");
        check(flush_done, 1, "R11", "ack-first ordering done");
        check(in_flush, 1, "R11", "still flushing");
        tick(0, 1, 0, 0, "R11");
        check(in_flush, 0, "R11", "flag clears");

        // R8: issue and ack together from zero
        do_reset();
        tick(1, 1, 0, 0, "R8");
        check(underflow_err, 0, "R8", "same-cycle pair accepted");
        tick(0, 1, 0, 0, "R8");
        check(underflow_err, 1, "R8", "count stayed zero");

        // R7: refused ack changes nothing, error sticky
        do_reset();
        tick(0, 1, 0, 0, "R7");
        check(underflow_err, 1, "R7", "underflow flagged");
        tick(1, 0, 0, 0, "R7");
        tick(0, 1, 0, 0, "R7");
        tick(0, 0, 0, 1, "R7");
        check(flush_done, 1, "R7", "count not wrapped by refused ack");
        check(underflow_err, 1, "R7", "sticky");

        // R9: saturation at 255
        do_reset();
        repeat (256) tick(1, 0, 0, 0, "R9");
        repeat (255) tick(0, 1, 0, 0, "R9");
        check(underflow_err, 0, "R9", "255 acks accepted");
        tick(0, 1, 0, 0, "R9");
        check(underflow_err, 1, "R9", "256th ack refused");

        // Seeded random traffic against the model
        do_reset();
        void'($urandom(32'h5eed_1234));
        for (int n = 0; n < 4000; n++) begin
            bit ri, ra, rd, rc;
            ri = ($urandom % 100) < 35;
            rd = ($urandom % 100) < 10;
            rc = ($urandom % 100) < 12;
            ra = (m_out > 0) && (($urandom % 100) < 40);
            tick(ri, ra, rd, rc, "R2");
        end
        finish_run();
    end
endmodule